// File: doc/BRIEF.md
# Set-Clear Control Register Bank

This block holds a small group of 16-bit control registers, the interrupt enable mask and the interrupt request flags, behind a simple word-wide processor bus. Software never loads these registers directly. Each write carries a polarity flag in bit 15: with the flag high, the ones in bits 14:0 turn the matching register bits on; with it low, the same ones turn them off. Zero bits in the write data leave the register untouched. This lets several agents flip individual bits without a read-modify-write.

Every register has two addresses: a write-only address that takes the set/clear command and a separate read-only address that returns the current value. The whole register page answers at its home base and is also repeated throughout a wide address window. Inside the window only byte-address bits 8:1 choose the register. The block drives an interrupt-pending output whenever an enabled request is present and the global enable bit is on.

Top module: `sc_ctrl_bank`

## Requirements
- R1: A write whose bit 15 is 1 sets every register bit whose data bit 14:0 is 1 and leaves all other bits unchanged.
- R2: A write whose bit 15 is 0 clears every register bit whose data bit 14:0 is 1 and leaves all other bits unchanged.
- R3: Bit 15 of a register always reads 0, and a read of a write-only or unassigned offset inside the window returns 0 with an acknowledge.
- R4: A write to a read-only offset changes no register.
- R5: The enable register is written at offset 0x09A and read at offset 0x01C. The request register is written at offset 0x09C and read at offset 0x01E. Offsets are the byte address modulo 0x200.
- R6: Accesses decode at the home page 0xDFF000–0xDFF1FF and at every byte address from 0xC00000 up to, but not including, 0xE00000, selecting the register by address bits 8:1 alone.
- R7: A request with an address outside those ranges produces no acknowledge, no register change and read data 0.
- R8: A request inside the ranges gives ack_o high in the following cycle, with rdata_o holding the read value in that same cycle. Reads return the value held before the request cycle's edge.
- R9: irq_o is 1 exactly when enable bit 14 is 1 and enable[13:0] AND request[13:0] is nonzero. It follows register changes in the same cycle.
- R10: After reset both registers are 0, and ack_o, rdata_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| ack_o | output | 1 | Registered acknowledge for a decoded access |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt pending |

## Verification
The bus acknowledge and a change of the interrupt output can land on the same clock edge. A set/clear write to the enable or request register that completes or breaks an enabled pair also moves irq_o on the edge that raises ack_o. The bench provokes this by building up a pending request and then writing the master enable bit, and later clearing the request bit. Right after each of those edges it samples both ack_o and irq_o and compares them against its own model of the two registers.

// File: rtl/sc_bank_pkg.sv
package sc_bank_pkg;
  localparam int DATA_W = 16;
  localparam int NREG   = 2;
  localparam int SEL_W  = 8;

  // register index 0: enable, 1: request
  localparam int IDX_ENA = 0;
  localparam int IDX_REQ = 1;

  // word selects = byte offset >> 1
  localparam logic [SEL_W-1:0] WR_SEL [NREG] = '{8'h4D, 8'h4E};
  localparam logic [SEL_W-1:0] RD_SEL [NREG] = '{8'h0E, 8'h0F};

  localparam int MASTER_BIT = 14;
  localparam int SRC_W      = 14;

  function automatic logic [DATA_W-2:0] sc_apply(input logic [DATA_W-2:0] cur,
                                                  input logic [DATA_W-1:0] cmd);
    if (cmd[DATA_W-1]) return cur | cmd[DATA_W-2:0];
    else               return cur & ~cmd[DATA_W-2:0];
  endfunction
endpackage

// File: rtl/sc_bank_dec.sv
module sc_bank_dec #(
  parameter int              ADDR_W = 24,
  parameter logic [23:0]     BASE   = 24'hDFF000,
  parameter logic [23:0]     WIN_LO = 24'hC00000,
  parameter logic [23:0]     WIN_HI = 24'hE00000
) (
  input  logic [ADDR_W-1:0]               addr_i,
  output logic                            hit_o,
  output logic [sc_bank_pkg::SEL_W-1:0]   sel_o
);
  localparam int PAGE_LSB = sc_bank_pkg::SEL_W + 1;

  logic in_win, in_home;

  always_comb begin
    in_win  = (addr_i >= WIN_LO[ADDR_W-1:0]) && (addr_i < WIN_HI[ADDR_W-1:0]);
    in_home = addr_i[ADDR_W-1:PAGE_LSB] == BASE[ADDR_W-1:PAGE_LSB];
    hit_o   = in_win || in_home;
    sel_o   = addr_i[PAGE_LSB-1:1];
  end
endmodule

// File: rtl/sc_reg.sv
module sc_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-2:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bits_q <= '0;
    else if (wr_en_i) bits_q <= sc_bank_pkg::sc_apply(bits_q, wdata_i);
  end

  assign q_o = {1'b0, bits_q};

  // R1
  set_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[DATA_W-1]) |=> ((q_o & $past(q_o)) == $past(q_o)));
  // R2
  clr_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wdata_i[DATA_W-1]) |=> ((q_o | $past(q_o)) == $past(q_o)));
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_o));
  // R3
  top_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[DATA_W-1] == 1'b0);
endmodule

// File: rtl/sc_irq.sv
module sc_irq #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] ena_i,
  input  logic [DATA_W-1:0] req_i,
  output logic              irq_o
);
  localparam int M = sc_bank_pkg::MASTER_BIT;
  localparam int S = sc_bank_pkg::SRC_W;

  logic [DATA_W-1:0] unused_bits;
  assign unused_bits = {ena_i[DATA_W-1], req_i[DATA_W-1:S]};

  always_comb irq_o = ena_i[M] && |(ena_i[S-1:0] & req_i[S-1:0]);
endmodule

// File: rtl/sc_ctrl_bank.sv
module sc_ctrl_bank #(
  parameter int          ADDR_W = 24,
  parameter logic [23:0] BASE   = 24'hDFF000,
  parameter logic [23:0] WIN_LO = 24'hC00000,
  parameter logic [23:0] WIN_HI = 24'hE00000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [23:0]       addr_i,
  input  logic [15:0]       wdata_i,
  output logic              ack_o,
  output logic [15:0]       rdata_o,
  output logic              irq_o
);
  import sc_bank_pkg::*;

  logic             hit;
  logic [SEL_W-1:0] sel;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [NREG-1:0]  wr_en;
  logic [DATA_W-1:0] rd_mux;

  sc_bank_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_en[i] = req_i && we_i && hit && (sel == WR_SEL[i]);
    sc_reg #(.DATA_W(DATA_W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en[i]),
      .wdata_i (wdata_i),
      .q_o     (regs[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (sel == RD_SEL[i]) rd_mux = regs[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i && hit;
      rdata_o <= (req_i && hit && !we_i) ? rd_mux : '0;
    end
  end

  sc_irq #(.DATA_W(DATA_W)) u_irq (
    .ena_i (regs[IDX_ENA]),
    .req_i (regs[IDX_REQ]),
    .irq_o (irq_o)
  );

  // R8
  ack_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(req_i));
  // R7
  out_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i < 24'hC00000) |=> (!ack_o && rdata_o == '0));
  // R6
  win_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[23:21] == 3'b110) |=> ack_o);
  // R3
  wr_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(we_i)) |-> rdata_o == '0);
  // R9
  irq_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> regs[IDX_ENA][MASTER_BIT]);
endmodule

// File: tb/sc_ctrl_bank_tb.sv
module sc_ctrl_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ack, irq;
  logic [15:0] rdata;

  int total = 0, bad = 0;
  bit done = 0;
  logic [14:0] ena_m = '0, req_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_ctrl_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return ena_m[14] && |(ena_m[13:0] & req_m[13:0]);
  endfunction

  task automatic bus(input logic w, input logic [23:0] a, input logic [15:0] d,
                     output logic a_o, output logic [15:0] r_o);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    a_o = ack; r_o = rdata;
  endtask

  function automatic logic [14:0] apply(input logic [14:0] c, input logic [15:0] d);
    return d[15] ? (c | d[14:0]) : (c & ~d[14:0]);
  endfunction

  task automatic t_reset();
    chk("R10 ack", ack, 0);
    chk("R10 rdata", rdata, 0);
    chk("R10 irq", irq, 0);
  endtask

  task automatic t_set_clear();
    logic a; logic [15:0] r;
    bus(1, 24'hC3F09A, 16'h3FFF, a, r); ena_m = apply(ena_m, 16'h3FFF);
    chk("R2 write ack", a, 1);
    bus(0, 24'hC3F01C, 0, a, r);
    chk("R2 cleared", r, 16'h0000);
    bus(1, 24'hC3F09A, 16'hBFFF, a, r); ena_m = apply(ena_m, 16'hBFFF);
    bus(0, 24'hC3F01C, 0, a, r);
    chk("R1 set", r, 16'h3FFF);
    chk("R8 read ack", a, 1);
    bus(1, 24'hDFF09A, 16'h0005, a, r); ena_m = apply(ena_m, 16'h0005);
    bus(0, 24'hDFF01C, 0, a, r);
    chk("R2 partial clear", r, {1'b0, ena_m});
    bus(1, 24'hDFF09A, 16'h8001, a, r); ena_m = apply(ena_m, 16'h8001);
    bus(0, 24'hDFF01C, 0, a, r);
    chk("R1 partial set", r, {1'b0, ena_m});
  endtask

  task automatic t_request();
    logic a; logic [15:0] r;
    bus(1, 24'hDFF09C, 16'h0600, a, r); req_m = apply(req_m, 16'h0600);
    bus(0, 24'hDFF01E, 0, a, r);
    chk("R5 request readback", r, {1'b0, req_m});
    bus(0, 24'hDFF01C, 0, a, r);
    chk("R5 enable separate", r, {1'b0, ena_m});
  endtask

  task automatic t_top_bit();
    logic a; logic [15:0] r;
    bus(1, 24'hDFF09C, 16'hFFFF, a, r); req_m = apply(req_m, 16'hFFFF);
    bus(0, 24'hDFF01E, 0, a, r);
    chk("R3 bit15 reads 0", r, 16'h7FFF);
    bus(0, 24'hDFF09C, 0, a, r);
    chk("R3 write-only read data", r, 0);
    chk("R3 write-only read ack", a, 1);
    bus(0, 24'hDFF1FE, 0, a, r);
    chk("R3 unassigned read", r, 0);
  endtask

  task automatic t_ro_ignore();
    logic a; logic [15:0] r;
    bus(1, 24'hDFF01E, 16'h0FFF, a, r);
    bus(1, 24'hDFF01C, 16'h8FFF, a, r);
    bus(0, 24'hDFF01E, 0, a, r);
    chk("R4 request unchanged", r, {1'b0, req_m});
    bus(0, 24'hDFF01C, 0, a, r);
    chk("R4 enable unchanged", r, {1'b0, ena_m});
  endtask

  task automatic t_outside();
    logic a; logic [15:0] r;
    bus(1, 24'hBFF09A, 16'h3FFF, a, r);
    chk("R7 low write no ack", a, 0);
    bus(1, 24'hE0009C, 16'h7FFF, a, r);
    chk("R7 high write no ack", a, 0);
    bus(0, 24'hE0001C, 0, a, r);
    chk("R7 boundary read no ack", a, 0);
    chk("R7 boundary read data", r, 0);
    bus(0, 24'hDFF01C, 0, a, r);
    chk("R7 enable untouched", r, {1'b0, ena_m});
    bus(0, 24'hDFF01E, 0, a, r);
    chk("R7 request untouched", r, {1'b0, req_m});
  endtask

  task automatic t_mirror();
    logic a; logic [15:0] r;
    bus(0, 24'hC0001C, 0, a, r);
    chk("R6 window start", r, {1'b0, ena_m});
    bus(0, 24'hDFFE1E, 0, a, r);
    chk("R6 window top mirror", r, {1'b0, req_m});
    bus(1, 24'hD4429C, 16'h7FFF, a, r); req_m = apply(req_m, 16'h7FFF);
    bus(0, 24'hC8201E, 0, a, r);
    chk("R6 mirror write/read", r, 0);
    bus(0, 24'hDFFFFE, 0, a, r);
    chk("R6 last word ack", a, 1);
  endtask

  task automatic t_irq();
    logic a; logic [15:0] r;
    bus(1, 24'hDFF09A, 16'h7FFF, a, r); ena_m = apply(ena_m, 16'h7FFF);
    chk("R9 all clear", irq, 0);
    bus(1, 24'hDFF09C, 16'h8008, a, r); req_m = apply(req_m, 16'h8008);
    chk("R9 request only", irq, 0);
    bus(1, 24'hDFF09A, 16'h8008, a, r); ena_m = apply(ena_m, 16'h8008);
    chk("R9 no master", irq, 0);
    bus(1, 24'hDFF09A, 16'hC000, a, r); ena_m = apply(ena_m, 16'hC000);
    chk("R9 master on ack", a, 1);
    chk("R9 master on irq", irq, exp_irq());
    bus(1, 24'hDFF09C, 16'h0008, a, r); req_m = apply(req_m, 16'h0008);
    chk("R9 request cleared ack", a, 1);
    chk("R9 request cleared irq", irq, exp_irq());
    bus(1, 24'hDFF09C, 16'h8004, a, r); req_m = apply(req_m, 16'h8004);
    chk("R9 unmatched source", irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_set_clear();
    t_request();
    t_top_bit();
    t_ro_ignore();
    t_outside();
    t_mirror();
    t_irq();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule